// File: doc/BRIEF.md
# Self-Timed EEPROM Program Sequencer

This block runs the programming side of a small serial EEPROM model. Once the serial front end has shifted in a complete erase or write command, it raises a one-cycle request with an operation code, a word address and a data word. The sequencer accepts the request only when the front end reports that programming is enabled and no earlier operation is still running. It then holds a busy flag for a fixed number of system clock cycles and updates a 64-word by 16-bit register array that stands in for the memory cells.

There are four operations. A word erase sets one word to all ones, and an array erase does the same to every word. A word write erases the target word and then programs it. An array write erases every word and then programs the same value into all of them. Each operation has its own busy length, set by a parameter. For the two writing operations, the first half of the busy window is the erase phase and the second half is the program phase, and the erased state can be seen between the two. After an operation starts, nothing on the request side can stop it or change it.

A registered read port serves the read path and freezes while busy. A separate combinational observation port shows any word at any time, for test.

Top module: `ep_prog_seq`

## Requirements
- R1: While reset is held, `busy_o` is 0 and `rd_data_o` is 0, and every array word is 16'hFFFF.
- R2: A request is accepted on a clock edge where `req_i` and `wr_en_i` are both 1 and `busy_o` is 0. `busy_o` is 1 from the next cycle for exactly the length of the operation. Operation codes on `op_i`: 2'b00 word erase and 2'b10 word write, both T_WORD cycles; 2'b01 array erase, T_ERAL cycles; 2'b11 array write, T_WRAL cycles.
- R3: A request made while `wr_en_i` is 0 starts nothing: `busy_o` stays 0 and no array word changes.
- R4: While `busy_o` is 1, new requests are ignored, and changes on `op_i`, `addr_i`, `data_i` and `wr_en_i` do not affect the running operation. Array words change only at its two commit edges.
- R5: A word erase leaves the addressed word at 16'hFFFF when busy ends, and every other word unchanged.
- R6: An array erase leaves every word at 16'hFFFF when busy ends.
- R7: A word write with length L reads 16'hFFFF at the addressed word from the edge L - L/2 cycles after acceptance. It holds the new data once busy ends. Other words are unchanged.
- R8: An array write with length L shows every word at 16'hFFFF from the edge L - L/2 cycles after acceptance. Every word holds the given data once busy ends.
- R9: While idle, `rd_data_o` returns the word at `rd_addr_i` one clock later. While `busy_o` is 1, it holds its last value whatever `rd_addr_i` does.
- R10: `tap_data_o` shows the current contents of the word at `tap_addr_i` with no clock delay, including while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_i | input | 1 | Operation request from the serial decoder |
| op_i | input | 2 | Operation code (see R2) |
| addr_i | input | ADDR_W | Target word address |
| data_i | input | DATA_W | Data word for the writing operations |
| wr_en_i | input | 1 | Programming-enabled state of the decoder |
| busy_o | output | 1 | High while an operation runs |
| rd_addr_i | input | ADDR_W | Read port address |
| rd_data_o | output | DATA_W | Registered read data, frozen while busy |
| tap_addr_i | input | ADDR_W | Observation address |
| tap_data_o | output | DATA_W | Unregistered contents of the observed word |

## Verification
The bound checker watches every cycle for the following: busy only rises after an enabled request, each busy window matches the length of the operation code that started it, and the read data stays frozen while busy. It also checks that the erase and program strobes never coincide, that the program strobe ends the window, and that the observed word changes only at a strobe. Only the bench scenarios can show the actual array contents. This covers the erased state at the midpoint of a write, the final data after word and array writes, the sparing of words that were not addressed, and the fact that a second request arriving mid-operation leaves no trace.

// File: rtl/ep_seq_pkg.sv
package ep_seq_pkg;
   typedef enum logic [1:0] {
      OP_ERASE_WORD = 2'b00,
      OP_ERASE_ALL  = 2'b01,
      OP_WRITE_WORD = 2'b10,
      OP_WRITE_ALL  = 2'b11
   } ep_op_e;

   // bit 0 selects every word, bit 1 adds a program phase after the erase
   function automatic logic op_is_all(input logic [1:0] op);
      return op[0];
   endfunction

   function automatic logic op_has_prog(input logic [1:0] op);
      return op[1];
   endfunction
endpackage

// File: rtl/ep_busy_timer.sv
module ep_busy_timer #(
   parameter int CW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [CW-1:0] len_i,
   input  logic          split_i,
   output logic          busy_o,
   output logic          erase_stb_o,
   output logic          prog_stb_o
);
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] mid_q;
   logic          split_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         mid_q   <= '0;
         split_q <= 1'b0;
         busy_o  <= 1'b0;
      end else if (start_i && !busy_o) begin
         cnt_q   <= len_i - 1'b1;
         mid_q   <= len_i >> 1;
         split_q <= split_i;
         busy_o  <= 1'b1;
      end else if (busy_o) begin
         if (cnt_q == '0) busy_o <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   // split runs erase at the half-way edge, program at the last edge;
   // plain erases commit on the last edge
   always_comb begin
      erase_stb_o = busy_o && (split_q ? (cnt_q == mid_q) : (cnt_q == '0));
      prog_stb_o  = busy_o && split_q && (cnt_q == '0);
   end
endmodule

// File: rtl/ep_word_array.sv
module ep_word_array #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              erase_stb_i,
   input  logic              prog_stb_i,
   input  logic              all_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_word_o,
   input  logic [ADDR_W-1:0] tap_addr_i,
   output logic [DATA_W-1:0] tap_word_o
);
   localparam int WORDS = 1 << ADDR_W;

   logic [WORDS-1:0][DATA_W-1:0] words;

   for (genvar g = 0; g < WORDS; g++) begin : g_word
      logic              sel;
      logic [DATA_W-1:0] word_q;

      assign sel = all_i || (addr_i == ADDR_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    word_q <= '1;
         else if (erase_stb_i && sel)   word_q <= '1;
         else if (prog_stb_i && sel)    word_q <= data_i;
      end

      assign words[g] = word_q;
   end

   assign rd_word_o  = words[rd_addr_i];
   assign tap_word_o = words[tap_addr_i];
endmodule

// File: rtl/ep_read_hold.sv
module ep_read_hold #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold_i,
   input  logic [DATA_W-1:0] word_i,
   output logic [DATA_W-1:0] data_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       data_o <= '0;
      else if (!hold_i) data_o <= word_i;
   end
endmodule

// File: rtl/ep_prog_seq.sv
module ep_prog_seq
   import ep_seq_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16,
   parameter int T_WORD = 40,
   parameter int T_ERAL = 120,
   parameter int T_WRAL = 300
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [1:0]        op_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              wr_en_i,
   output logic              busy_o,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic [ADDR_W-1:0] tap_addr_i,
   output logic [DATA_W-1:0] tap_data_o
);
   localparam int T_MAX_A = (T_WORD > T_ERAL) ? T_WORD : T_ERAL;
   localparam int T_MAX   = (T_MAX_A > T_WRAL) ? T_MAX_A : T_WRAL;
   localparam int CW      = $clog2(T_MAX + 1);

   if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_addr
      $error("ep_prog_seq: ADDR_W must lie in 1..8");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("ep_prog_seq: DATA_W must be positive");
   end
   if (T_WORD < 4 || T_ERAL < 4 || T_WRAL < 4) begin : g_bad_time
      $error("ep_prog_seq: every busy length needs at least 4 cycles");
   end

   logic              accept;
   logic [CW-1:0]     run_len;
   logic              all_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              ers_stb;
   logic              prg_stb;
   logic [DATA_W-1:0] rd_word;

   assign accept = req_i && wr_en_i && !busy_o;

   always_comb begin
      unique case (op_i)
         OP_ERASE_WORD, OP_WRITE_WORD: run_len = CW'(T_WORD);
         OP_ERASE_ALL:                 run_len = CW'(T_ERAL);
         default:                      run_len = CW'(T_WRAL);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         all_q  <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
      end else if (accept) begin
         all_q  <= op_is_all(op_i);
         addr_q <= addr_i;
         data_q <= data_i;
      end
   end

   ep_busy_timer #(.CW(CW)) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (accept),
      .len_i       (run_len),
      .split_i     (op_has_prog(op_i)),
      .busy_o      (busy_o),
      .erase_stb_o (ers_stb),
      .prog_stb_o  (prg_stb)
   );

   ep_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
      .clk         (clk),
      .rst_n       (rst_n),
      .erase_stb_i (ers_stb),
      .prog_stb_i  (prg_stb),
      .all_i       (all_q),
      .addr_i      (addr_q),
      .data_i      (data_q),
      .rd_addr_i   (rd_addr_i),
      .rd_word_o   (rd_word),
      .tap_addr_i  (tap_addr_i),
      .tap_word_o  (tap_data_o)
   );

   ep_read_hold #(.DATA_W(DATA_W)) u_rd (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold_i (busy_o),
      .word_i (rd_word),
      .data_o (rd_data_o)
   );
endmodule

// File: rtl/ep_prog_seq_chk.sv
module ep_prog_seq_chk #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16,
   parameter int T_WORD = 40,
   parameter int T_ERAL = 120,
   parameter int T_WRAL = 300
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_i,
   input logic              wr_en_i,
   input logic [1:0]        op_i,
   input logic              busy_o,
   input logic [DATA_W-1:0] rd_data_o,
   input logic [ADDR_W-1:0] tap_addr_i,
   input logic [DATA_W-1:0] tap_data_o,
   input logic              ers_stb,
   input logic              prg_stb
);
   logic [31:0] run_cnt;
   logic [31:0] exp_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
         exp_len <= '0;
      end else if (req_i && wr_en_i && !busy_o) begin
         run_cnt <= '0;
         exp_len <= (op_i == 2'b01) ? 32'(T_ERAL) :
                    (op_i == 2'b11) ? 32'(T_WRAL) : 32'(T_WORD);
      end else if (busy_o) begin
         run_cnt <= run_cnt + 1;
      end
   end

   assert_start_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(req_i && wr_en_i));

   assert_busy_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (run_cnt == exp_len));

   assert_no_start_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !(req_i && wr_en_i)) |=> !busy_o);

   assert_strobe_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ers_stb || prg_stb) |-> busy_o);

   assert_tap_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ers_stb && !prg_stb) |=> ($stable(tap_data_o) || !$stable(tap_addr_i)));

   assert_strobe_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ers_stb, prg_stb}));

   assert_prog_ends_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      prg_stb |=> !busy_o);

   assert_read_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> $stable(rd_data_o));
endmodule

bind ep_prog_seq ep_prog_seq_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W),
   .T_WORD(T_WORD), .T_ERAL(T_ERAL), .T_WRAL(T_WRAL)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_i      (req_i),
   .wr_en_i    (wr_en_i),
   .op_i       (op_i),
   .busy_o     (busy_o),
   .rd_data_o  (rd_data_o),
   .tap_addr_i (tap_addr_i),
   .tap_data_o (tap_data_o),
   .ers_stb    (ers_stb),
   .prg_stb    (prg_stb)
);

// File: tb/ep_prog_seq_tb.sv
module ep_prog_seq_tb;
   localparam int AW = 6;
   localparam int DW = 16;
   localparam int NW = 1 << AW;
   localparam int TW = 40;
   localparam int TE = 120;
   localparam int TA = 300;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic [1:0]    op_in = 2'b00;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] data = '0;
   logic          wr_en = 1'b0;
   logic          busy;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic [AW-1:0] tap_addr = '0;
   logic [DW-1:0] tap_data;

   int checks = 0;
   int errors = 0;
   int pushed = 0;
   int done = 0;
   bit finished = 1'b0;
   logic [DW-1:0] model [NW];
   int    len_q [$];
   string tag_q [$];

   ep_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .T_WORD(TW), .T_ERAL(TE), .T_WRAL(TA)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .op_i(op_in), .addr_i(addr),
      .data_i(data), .wr_en_i(wr_en), .busy_o(busy), .rd_addr_i(rd_addr),
      .rd_data_o(rd_data), .tap_addr_i(tap_addr), .tap_data_o(tap_data)
   );

   always #10 clk = ~clk;

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic sweep(input string rq);
      int bad = 0;
      logic [DW-1:0] a1 = '0;
      logic [DW-1:0] e1 = '0;
      for (int i = 0; i < NW; i++) begin
         tap_addr = AW'(i);
         #1;
         if (tap_data !== model[i]) begin
            if (bad == 0) begin a1 = tap_data; e1 = model[i]; end
            bad++;
         end
      end
      chk(bad == 0, rq, "array contents", 32'(a1), 32'(e1));
   endtask

   function automatic int len_of(input logic [1:0] op);
      return (op == 2'b01) ? TE : (op == 2'b11) ? TA : TW;
   endfunction

   // driver side of the scoreboard: expected length and final model
   task automatic expect_op(input logic [1:0] op, input int a, input logic [DW-1:0] d,
                            input string rq);
      len_q.push_back(len_of(op));
      tag_q.push_back(rq);
      pushed++;
      for (int i = 0; i < NW; i++) begin
         if (op[0] || i == a) model[i] = op[1] ? d : '1;
      end
   endtask

   task automatic issue(input logic [1:0] op, input int a, input logic [DW-1:0] d,
                        input logic en);
      @(negedge clk);
      req = 1'b1; op_in = op; addr = AW'(a); data = d; wr_en = en;
      @(negedge clk);
      req = 1'b0; wr_en = 1'b0;
   endtask

   task automatic wait_done();
      wait (done == pushed);
   endtask

   task automatic run_op(input logic [1:0] op, input int a, input logic [DW-1:0] d,
                         input string rq);
      expect_op(op, a, d, rq);
      issue(op, a, d, 1'b1);
      wait_done();
   endtask

   // write with a look at the erased midpoint through the tap port
   task automatic run_mid(input logic [1:0] op, input int a, input logic [DW-1:0] d,
                          input int probe, input string rq);
      logic [DW-1:0] old = model[probe];
      int L = len_of(op);
      int M = L - L / 2;
      expect_op(op, a, d, rq);
      tap_addr = AW'(probe);
      issue(op, a, d, 1'b1);
      chk(busy === 1'b1, "R2", "busy after accept", 32'(busy), 1);
      repeat (M - 1) @(negedge clk);
      chk(tap_data === old, rq, "before erase half ends", 32'(tap_data), 32'(old));
      @(negedge clk);
      chk(tap_data === '1, rq, "erased at midpoint", 32'(tap_data), 32'hFFFF);
      wait_done();
   endtask

   // monitor side: pop expected length as each busy window closes
   initial begin
      bit in_run = 1'b0;
      int n = 0;
      int exp_n;
      string rq;
      forever begin
         @(negedge clk);
         if (rst_n && busy) begin
            if (!in_run) begin in_run = 1'b1; n = 0; end
            n++;
         end else if (in_run) begin
            in_run = 1'b0;
            exp_n = len_q.pop_front();
            rq = tag_q.pop_front();
            chk(n == exp_n, "R2", "busy length", 32'(n), 32'(exp_n));
            sweep(rq);
            done++;
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog run did not finish actual=0 expected=1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NW; i++) model[i] = '1;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(busy === 1'b0, "R1", "busy in reset", 32'(busy), 0);
      chk(rd_data === '0, "R1", "read data in reset", 32'(rd_data), 0);
      sweep("R1");
      rst_n = 1'b1;

      // R3 disabled request
      issue(2'b10, 5, 16'h1234, 1'b0);
      repeat (3) @(negedge clk);
      chk(busy === 1'b0, "R3", "busy with write disabled", 32'(busy), 0);
      sweep("R3");

      run_op(2'b10, 5, 16'h1234, "R7");
      run_op(2'b10, 9, 16'hA5A5, "R7");

      // R9 read before, during and after a busy window; R4 hostile request
      rd_addr = AW'(5);
      repeat (2) @(negedge clk);
      chk(rd_data === 16'h1234, "R9", "idle read", 32'(rd_data), 32'h1234);
      begin
         int M = TW - TW / 2;
         expect_op(2'b10, 5, 16'h00F0, "R4");
         tap_addr = AW'(5);
         issue(2'b10, 5, 16'h00F0, 1'b1);
         @(negedge clk);
         req = 1'b1; op_in = 2'b11; addr = AW'(9); data = 16'h0000; wr_en = 1'b1;
         @(negedge clk);
         req = 1'b0; wr_en = 1'b0; addr = '0; data = 16'hFFFF; op_in = 2'b00;
         repeat (M - 3) @(negedge clk);
         chk(tap_data === 16'h1234, "R10", "tap before midpoint", 32'(tap_data), 32'h1234);
         rd_addr = AW'(7);
         @(negedge clk);
         chk(tap_data === 16'hFFFF, "R7", "word erased mid write", 32'(tap_data), 32'hFFFF);
         chk(rd_data === 16'h1234, "R9", "read frozen while busy", 32'(rd_data), 32'h1234);
         wait_done();
      end
      @(negedge clk);
      chk(rd_data === 16'hFFFF, "R9", "read after busy", 32'(rd_data), 32'hFFFF);
      rd_addr = AW'(5);
      @(negedge clk);
      chk(rd_data === 16'h00F0, "R9", "read new word", 32'(rd_data), 32'h00F0);

      run_op(2'b00, 5, 16'h0000, "R5");
      run_op(2'b10, 0, 16'h0001, "R7");
      run_op(2'b10, NW - 1, 16'h8000, "R7");
      run_mid(2'b11, 0, 16'h3C3C, 9, "R8");
      run_op(2'b10, 33, 16'h7E7E, "R7");
      run_op(2'b01, 0, 16'h0000, "R6");

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule